// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting channel of a legacy-style interval timer, together with the decoder for its command byte. A host reaches it over a byte-wide bus with two addresses: the command address, which can only be written, and the channel data address, which takes reload bytes and returns count bytes. The counter steps once per pulse on `cntEn`, a slow clock-enable that stands for the fixed timer input frequency of about 1.19 MHz. The channel drives the single output `timerOut`.

Two operating behaviours are modelled: a rate generator that gives one short low pulse per period, and a square-wave generator. Counting is always binary. A command byte that selects any other mode code is still accepted and stored. In that case the counter decrements freely and the output stays high. The host can freeze a snapshot of the running count with a latch command. It then reads the snapshot back a byte at a time while the live counter keeps moving.

Top module: `pit_channel`

## Requirements
- R1: In a byte written to the command address, bits [7:6] select the channel, bits [5:4] the access type, bits [3:1] the mode and bit 0 the number format. Only the channel number equal to parameter CHAN_ID (default 0) is acted on. Bytes naming any other channel, including 11, change nothing. Bit 0 is ignored, so counting is binary. Bit 3 does not change behaviour, so mode codes 110 and 111 act as 010 and 011.
- R2: With access type 01 (low only) a data write sets the reload to {8'h00, byte}. With access type 10 (high only) it sets the reload to {byte, 8'h00}. In either case a data read returns only that one byte of the count on every read.
- R3: With access type 11 the first data write is the low byte and the second is the high byte. Data reads also alternate, low byte first and then high byte.
- R4: A reload takes effect on the first `cntEn` pulse after its final byte is written, which loads the counter. Each later pulse steps the counter. A reload of 0 counts as 65536.
- R5: In mode 010 (rate generator) with reload N ≥ 2, `timerOut` is low while the count equals 1 and high otherwise. On the pulse that finds the count at 1, the counter reloads N, so the period is N pulses.
- R6: In mode 011 (square wave) the counter steps from N down to 1 and then reloads. `timerOut` is high while the count, with 0 taken as 65536, is greater than N/2 rounded down. This makes the high half one pulse longer when N is odd.
- R7: A command with access type 00 copies the current count into a hold register. Data reads then return bytes of the held value while the counter keeps running. The hold is released when the last byte for the current access type has been read.
- R8: A latch command issued while a held value is still unread has no effect on the held value or on the byte order of the reads.
- R9: A command that is not a latch stops the channel and drives `timerOut` high. It also clears any hold and resets both the write and read byte order to low first. With mode codes 000, 001, 100 or 101 the channel counts down freely, wrapping from 0 to 65535, and `timerOut` stays high.
- R10: A read of the command address returns 8'h00.
- R11: After reset the access type is 11, the count is 0, the channel is stopped and `timerOut` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe, one cycle per byte |
| busAddr | input | 1 | 0 selects the channel data address, 1 selects the command address |
| busWrData | input | 8 | Write data byte |
| busRdData | output | 8 | Read data byte, valid in the cycle that `busRd` is high |
| cntEn | input | 1 | One-cycle pulse at the timer input rate |
| timerOut | output | 1 | Channel output |

## Verification
The two cases that are hardest to reach are the 65536-pulse count that follows a reload of 0 and the interleaving of latch commands with half-finished byte sequences. The first only resolves after the counter has run through its full wrap. The stimulus therefore runs `cntEn` on every cycle for a little more than 65536 cycles, once in each modelled mode. For the latch cases the bench issues a second latch between the snapshot and its reads, and leaves a two-byte reload half written before a new command. The behavioural model tracks every byte-order toggle, so any slip shows up in a later read.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LOW   = 2'b01;
  localparam logic [1:0] ACC_HIGH  = 2'b10;
  localparam logic [1:0] ACC_PAIR  = 2'b11;

  typedef enum logic [1:0] {
    KIND_FREE   = 2'd0,
    KIND_RATE   = 2'd1,
    KIND_SQUARE = 2'd2
  } countKind_e;

  typedef struct packed {
    logic stageLow;
    logic loadLow;
    logic loadHigh;
    logic loadPair;
    logic latchReq;
    logic latchFree;
    logic stopCount;
  } chanStrobes_t;

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busWr,
  input  logic         busRd,
  input  logic         busAddr,
  input  logic [5:0]   cmdBits,   // {channel[1:0], access[1:0], modeLow[1:0]}
  input  logic         isLatched,
  output chanStrobes_t strb,
  output countKind_e   kind,
  output logic         rdHighSel
);

  localparam logic [1:0] CHAN_SEL = 2'(CHAN_ID);

  logic [1:0] accMode;
  logic [1:0] modeLo;
  logic       wrFlip;
  logic       rdFlip;
  logic       ctrlWr;
  logic       dataWr;
  logic       dataRd;

  assign ctrlWr = busWr && busAddr && (cmdBits[5:4] == CHAN_SEL);
  assign dataWr = busWr && !busAddr;
  assign dataRd = busRd && !busAddr;

  always_comb begin
    strb           = '0;
    strb.stopCount = ctrlWr && (cmdBits[3:2] != ACC_LATCH);
    strb.latchReq  = ctrlWr && (cmdBits[3:2] == ACC_LATCH);
    strb.loadLow   = dataWr && (accMode == ACC_LOW);
    strb.loadHigh  = dataWr && (accMode == ACC_HIGH);
    strb.stageLow  = dataWr && (accMode == ACC_PAIR) && !wrFlip;
    strb.loadPair  = dataWr && (accMode == ACC_PAIR) && wrFlip;
    strb.latchFree = dataRd && ((accMode != ACC_PAIR) || rdFlip);
  end

  always_comb begin
    case (modeLo)
      2'b10:   kind = KIND_RATE;
      2'b11:   kind = KIND_SQUARE;
      default: kind = KIND_FREE;
    endcase
  end

  assign rdHighSel = (accMode == ACC_HIGH) || ((accMode == ACC_PAIR) && rdFlip);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMode <= ACC_PAIR;
      modeLo  <= 2'b00;
      wrFlip  <= 1'b0;
      rdFlip  <= 1'b0;
    end else begin
      if (strb.stopCount) begin
        accMode <= cmdBits[3:2];
        modeLo  <= cmdBits[1:0];
        wrFlip  <= 1'b0;
        rdFlip  <= 1'b0;
      end else if (strb.latchReq && !isLatched) begin
        rdFlip <= 1'b0;
      end
      if (dataWr && (accMode == ACC_PAIR)) wrFlip <= !wrFlip;
      if (dataRd && (accMode == ACC_PAIR)) rdFlip <= !rdFlip;
    end
  end

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  chanStrobes_t      strb,
  input  countKind_e        kind,
  input  logic              rdHighSel,
  output logic [BYTE_W-1:0] busRdData,
  output logic              timerOut,
  output logic              isLatched,
  output logic              isRunning
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam int EXT_W = CNT_W + 1;

  logic [BYTE_W-1:0] lowStage;
  logic [CNT_W-1:0]  reloadVal;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  nextCount;
  logic [CNT_W-1:0]  latchVal;
  logic [CNT_W-1:0]  rdSource;
  logic              loadPending;
  logic [EXT_W-1:0]  effCount;
  logic [EXT_W-1:0]  halfPoint;
  logic              anyLoad;

  assign anyLoad = strb.loadLow || strb.loadHigh || strb.loadPair;

  always_comb begin
    if ((kind != KIND_FREE) && (count == CNT_W'(1))) nextCount = reloadVal;
    else                                              nextCount = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowStage  <= '0;
      reloadVal <= '0;
    end else begin
      if (strb.stageLow) lowStage  <= busWrData;
      if (strb.loadLow)  reloadVal <= {{BYTE_W{1'b0}}, busWrData};
      if (strb.loadHigh) reloadVal <= {busWrData, {BYTE_W{1'b0}}};
      if (strb.loadPair) reloadVal <= {busWrData, lowStage};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= '0;
      loadPending <= 1'b0;
      isRunning   <= 1'b0;
      isLatched   <= 1'b0;
      latchVal    <= '0;
    end else if (strb.stopCount) begin
      loadPending <= 1'b0;
      isRunning   <= 1'b0;
      isLatched   <= 1'b0;
    end else begin
      if (cntEn) begin
        if (loadPending) begin
          count       <= reloadVal;
          isRunning   <= 1'b1;
          loadPending <= 1'b0;
        end else if (isRunning) begin
          count <= nextCount;
        end
      end
      if (anyLoad) loadPending <= 1'b1;
      if (strb.latchReq && !isLatched) begin
        latchVal  <= count;
        isLatched <= 1'b1;
      end
      if (strb.latchFree) isLatched <= 1'b0;
    end
  end

  assign effCount  = (count == '0) ? (EXT_W'(1) << CNT_W) : EXT_W'(count);
  assign halfPoint = (reloadVal == '0) ? (EXT_W'(1) << (CNT_W - 1)) : EXT_W'(reloadVal >> 1);

  always_comb begin
    if (!isRunning) timerOut = 1'b1;
    else begin
      case (kind)
        KIND_RATE:   timerOut = (count != CNT_W'(1));
        KIND_SQUARE: timerOut = (effCount > halfPoint);
        default:     timerOut = 1'b1;
      endcase
    end
  end

  assign rdSource  = isLatched ? latchVal : count;
  assign busRdData = busAddr   ? '0
                   : (rdHighSel ? rdSource[CNT_W-1:BYTE_W] : rdSource[BYTE_W-1:0]);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       cntEn,
  output logic       timerOut
);

  chanStrobes_t strb;
  countKind_e   kind;
  logic         rdHighSel;
  logic         isLatched;
  logic         isRunning;

  pit_ctrl #(.CHAN_ID(CHAN_ID)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busRd     (busRd),
    .busAddr   (busAddr),
    .cmdBits   ({busWrData[7:4], busWrData[2:1]}),
    .isLatched (isLatched),
    .strb      (strb),
    .kind      (kind),
    .rdHighSel (rdHighSel)
  );

  pit_datapath #(.BYTE_W(8)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .cntEn     (cntEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .strb      (strb),
    .kind      (kind),
    .rdHighSel (rdHighSel),
    .busRdData (busRdData),
    .timerOut  (timerOut),
    .isLatched (isLatched),
    .isRunning (isRunning)
  );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CHAN_ID = 0
) (
  input logic       clk,
  input logic       rstN,
  input logic       busWr,
  input logic       busRd,
  input logic       busAddr,
  input logic [7:0] busWrData,
  input logic [7:0] busRdData,
  input logic       cntEn,
  input logic       timerOut,
  input logic       isLatched,
  input logic       isRunning
);

  localparam logic [1:0] CHAN_SEL = 2'(CHAN_ID);

  logic cmdOwn;
  assign cmdOwn = busWr && busAddr && (busWrData[7:6] == CHAN_SEL);

  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr) |-> (busRdData == 8'h00)); // R10

  AST_CMD_STOPS_OUT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOwn && (busWrData[5:4] != 2'b00)) |=> (timerOut && !isRunning)); // R9

  AST_SECOND_LATCH_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOwn && (busWrData[5:4] == 2'b00) && isLatched && !busRd) |=> isLatched); // R8

  AST_START_ON_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isRunning) |-> $past(cntEn)); // R4

  AST_LATCH_SETS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOwn && (busWrData[5:4] == 2'b00)) |=> isLatched); // R7

endmodule

bind pit_channel pit_channel_chk #(.CHAN_ID(CHAN_ID)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busWr     (busWr),
  .busRd     (busRd),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .cntEn     (cntEn),
  .timerOut  (timerOut),
  .isLatched (isLatched),
  .isRunning (isRunning)
);

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic       cntEn = 1'b0;
  wire  [7:0] busRdData;
  wire        timerOut;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;
  int cenPeriod = 0;
  int cenCnt = 0;

  // behavioural reference state
  int mAcc, mMode, mWrFlip, mRdFlip, mLowStage, mReload, mCount;
  bit mPending, mRunning, mLatched;
  int mLatchVal;

  pit_channel #(.CHAN_ID(0)) dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .cntEn(cntEn), .timerOut(timerOut)
  );

  always #2 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int modelKind();
    if (mMode == 2) return 1;
    if (mMode == 3) return 2;
    return 0;
  endfunction

  function automatic bit modelOut();
    int eff, half;
    if (!mRunning) return 1'b1;
    case (modelKind())
      1: return mCount != 1;
      2: begin
        eff  = (mCount == 0) ? 65536 : mCount;
        half = (mReload == 0) ? 32768 : mReload / 2;
        return eff > half;
      end
      default: return 1'b1;
    endcase
  endfunction

  function automatic int modelRdByte();
    int src;
    src = mLatched ? mLatchVal : mCount;
    if (mAcc == 2 || (mAcc == 3 && mRdFlip != 0)) return (src >> 8) & 255;
    return src & 255;
  endfunction

  function automatic string outTag();
    if (!mRunning) return "R9";
    case (modelKind())
      1: return "R5";
      2: return "R6";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mAcc = 3; mMode = 0; mWrFlip = 0; mRdFlip = 0; mLowStage = 0;
      mReload = 0; mCount = 0; mPending = 0; mRunning = 0; mLatched = 0; mLatchVal = 0;
    end else begin
      automatic bit ctrlW  = busWr && busAddr && (busWrData[7:6] == 2'b00);
      automatic bit dataW  = busWr && !busAddr;
      automatic bit dataR  = busRd && !busAddr;
      automatic int fld    = int'(busWrData[5:4]);
      automatic bit stop   = ctrlW && fld != 0;
      automatic bit latchQ = ctrlW && fld == 0;
      automatic bit load   = dataW && (mAcc == 1 || mAcc == 2 || (mAcc == 3 && mWrFlip != 0));
      automatic bit free   = dataR && (mAcc != 3 || mRdFlip != 0);
      automatic int oldCount = mCount;
      automatic bit oldLatched = mLatched;
      if (stop) begin
        mRunning = 0; mPending = 0; mLatched = 0;
      end else begin
        if (cntEn) begin
          if (mPending) begin
            mCount = mReload; mRunning = 1; mPending = 0;
          end else if (mRunning) begin
            if (modelKind() != 0 && mCount == 1) mCount = mReload;
            else mCount = (mCount + 65535) % 65536;
          end
        end
        if (load) mPending = 1;
        if (latchQ && !oldLatched) begin mLatchVal = oldCount; mLatched = 1; end
        if (free) mLatched = 0;
      end
      if (dataW) begin
        case (mAcc)
          1: mReload = int'(busWrData);
          2: mReload = int'(busWrData) * 256;
          3: if (mWrFlip == 0) mLowStage = int'(busWrData);
             else mReload = int'(busWrData) * 256 + mLowStage;
          default: ;
        endcase
      end
      if (stop) begin
        mAcc = fld; mMode = int'(busWrData[2:1]); mWrFlip = 0; mRdFlip = 0;
      end else if (latchQ && !oldLatched) begin
        mRdFlip = 0;
      end
      if (dataW && mAcc == 3) mWrFlip = 1 - mWrFlip;
      if (dataR && mAcc == 3) mRdFlip = 1 - mRdFlip;
    end
  end

  // clock-enable generator and per-cycle output comparison
  always @(negedge clk) begin
    if (cenPeriod == 0) begin
      cntEn = 1'b0; cenCnt = 0;
    end else begin
      cntEn = (cenCnt == 0);
      cenCnt = (cenCnt + 1) % cenPeriod;
    end
    if (rstN) check(timerOut === modelOut(), outTag(), int'(timerOut), int'(modelOut()));
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(bit a, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0; busAddr = 1'b0;
  endtask

  task automatic busRead(bit a, string req);
    int exp;
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    #1;
    exp = a ? 0 : modelRdByte();
    check(busRdData === 8'(exp), req, int'(busRdData), exp);
    @(negedge clk);
    busRd = 1'b0; busAddr = 1'b0;
  endtask

  initial begin
    #760000;
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    // R11: reset state
    check(timerOut === 1'b1, "R11", int'(timerOut), 1);
    busRead(0, "R11");
    busRead(0, "R11");
    // R10: command address reads zero
    busRead(1, "R10");

    // R5: rate generator, reload 5, slow enable
    cenPeriod = 3;
    busWrite(1, 8'h34); busWrite(0, 8'd5); busWrite(0, 8'd0);
    waitCyc(60);
    // R7: latch, wait, read frozen value
    busWrite(1, 8'h00); waitCyc(9);
    busRead(0, "R7"); busRead(0, "R7");
    // R8: second latch ignored
    busWrite(1, 8'h00); waitCyc(4);
    busWrite(1, 8'h00); waitCyc(7);
    busRead(0, "R8"); busRead(0, "R8");
    // R3: live pair reads
    busRead(0, "R3"); busRead(0, "R3");

    // R6: square wave odd and even
    busWrite(1, 8'h36); busWrite(0, 8'd7); busWrite(0, 8'd0);
    waitCyc(120);
    busWrite(1, 8'h36); busWrite(0, 8'd6); busWrite(0, 8'd0);
    waitCyc(100);

    // R2: low-only access in square mode
    busWrite(1, 8'h16); busWrite(0, 8'd9);
    waitCyc(80);
    busRead(0, "R2"); busRead(0, "R2");
    // R2: high-only access in rate mode, reload 256
    cenPeriod = 1;
    busWrite(1, 8'h24); busWrite(0, 8'd1);
    waitCyc(700);
    busRead(0, "R2"); busRead(0, "R2");

    // R1: alias mode code 110 and ignored format bit
    cenPeriod = 2;
    busWrite(1, 8'h3C); busWrite(0, 8'd4); busWrite(0, 8'd0);
    waitCyc(40);
    busWrite(1, 8'h35); busWrite(0, 8'h10); busWrite(0, 8'd0);
    waitCyc(60);
    // R1: commands for other channels change nothing
    busWrite(1, 8'h76); waitCyc(20);
    busWrite(1, 8'hF0); waitCyc(20);
    busRead(0, "R1"); busRead(0, "R1");

    // R9: command resets write order mid-pair
    busWrite(1, 8'h34); busWrite(0, 8'h10);
    busWrite(1, 8'h34); busWrite(0, 8'd3); busWrite(0, 8'd0);
    waitCyc(30);
    // R9: latch cleared by a new command
    busWrite(1, 8'h00); waitCyc(5);
    busWrite(1, 8'h34);
    busRead(0, "R9"); busRead(0, "R9");
    // R9: unsupported mode counts freely with output high
    busWrite(1, 8'h30); busWrite(0, 8'd3); busWrite(0, 8'd0);
    waitCyc(20);
    busRead(0, "R9"); busRead(0, "R9");

    // R4: reload 0 means 65536 in both modelled modes
    cenPeriod = 1;
    busWrite(1, 8'h34); busWrite(0, 8'd0); busWrite(0, 8'd0);
    waitCyc(66000);
    busRead(0, "R4"); busRead(0, "R4");
    busWrite(1, 8'h36); busWrite(0, 8'd0); busWrite(0, 8'd0);
    waitCyc(66000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule